// File: doc/BRIEF.md
# Vector AES Encryption Round Unit

This block applies one middle round of AES encryption to up to four independent 128-bit states packed side by side in a 512-bit vector. Each lane first rotates its rows, then substitutes every byte through the AES S-box, then mixes each column, and finally XORs in a 128-bit round key taken from the same lane of the key operand. The block covers every encryption round except the last one, because the column mixing is always applied. It does not expand keys.

A two-bit lane code selects how many lanes are computed: one, two or four. A form bit chooses between two operand styles. In the three-operand form, the states come from a source vector and every lane that is not computed is written as zero. In the legacy two-operand form, exactly one lane is computed. Its state is read from the destination vector, and the upper lanes of the destination come back unchanged. A valid strobe goes in, and the result comes out one clock later through a single register stage. A lane mask comes with the result and shows which lanes carry a computed round.

Top module: `vec_aes_round`

## Requirements
- R1: While reset is asserted, `out_valid` is 0 and `out_lane_mask` is 0.
- R2: `out_valid` rises on the clock edge after a cycle in which `in_valid` is 1, and is 0 after a cycle in which `in_valid` is 0. While `out_valid` is 0, `out_data` holds the last result.
- R3: A computed lane gives MixColumns(SubBytes(ShiftRows(s))) XOR k. Byte i of a lane sits at bits [8i+7:8i]. Byte i belongs to column i/4 and row i%4. Row r rotates left by r byte positions. Example: the state with bytes 00,10,20,...,f0 (byte 0 first) and the key d6aa74fd d2af72fa daa678f1 d6ab76fe give 89d810e8 855ace68 2d1843d8 cb128fe4, written in the same byte order.
- R4: Lane n (bits [128n+127:128n]) uses the state and the key from lane n of their operands, independently of the other lanes.
- R5: In the three-operand form, `in_lanes_code` values 0, 1, 2 and 3 compute 1, 2, 4 and 4 lanes. `out_lane_mask` bit n is 1 exactly when lane n was computed, so the mask is 0001, 0011 or 1111.
- R6: In the three-operand form (`in_legacy`=0), every lane at or above the computed lane count is written as all zeros.
- R7: In the legacy form (`in_legacy`=1), only lane 0 is computed, and the lane code is ignored. The state comes from lane 0 of `in_dest`, and the key comes from lane 0 of `in_key`. `in_src1` is ignored. Lanes 1 to 3 equal the matching lanes of `in_dest`, and the mask is 0001.
- R8: The S-box maps 0x00 to 0x63 and 0x52 to 0x00. So an all-zero state gives {16{63}} XOR k, and an all-0x52 state gives k.
- R9: In the three-operand form, `in_dest` has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands are valid this cycle |
| in_legacy | input | 1 | 1 selects the legacy two-operand form |
| in_lanes_code | input | 2 | Lane count code (0: 1, 1: 2, 2 and 3: 4) |
| in_dest | input | 512 | Destination vector (state and upper lanes in legacy form) |
| in_src1 | input | 512 | State vector in the three-operand form |
| in_key | input | 512 | Round key vector, one key per lane |
| out_valid | output | 1 | Result valid |
| out_data | output | 512 | Result vector |
| out_lane_mask | output | 4 | Lanes that carry a computed round |

## Verification
The bench builds the block with its default four lanes of 128 bits. This makes every lane code reachable, including the code 3 alias, and gives the legacy form three upper lanes to preserve. Expected lanes come from the published first-round vector and from two S-box fixed values (zero state and all-0x52 state). They also come from the fact that the key enters by XOR, so changing the key shifts the output by the key difference. These vectors are placed in different lanes, in varied orders, so that any crossing of lanes or keys shows up.

// File: rtl/vec_aes_pkg.sv
package vec_aes_pkg;
  localparam int BYTE_W     = 8;
  localparam int LANE_BYTES = 16;
  localparam int LANE_W     = LANE_BYTES * BYTE_W;
  localparam int COLS       = 4;
  localparam int ROWS       = 4;

  function automatic logic [7:0] gf_dbl(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_dbl(sh);
    end
    return acc;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] a, input int n);
    return (a << n) | (a >> (8 - n));
  endfunction
endpackage

// File: rtl/aes_sbox_calc.sv
module aes_sbox_calc
  import vec_aes_pkg::*;
(
  input  logic [7:0] a,
  output logic [7:0] y
);
  logic [7:0] p2, p3, p6, p12, p15, p30, p60, p120, p240, p252, inv;

  // inverse as a^254 (0 maps to 0)
  always_comb begin
    p2   = gf_mul(a, a);
    p3   = gf_mul(p2, a);
    p6   = gf_mul(p3, p3);
    p12  = gf_mul(p6, p6);
    p15  = gf_mul(p12, p3);
    p30  = gf_mul(p15, p15);
    p60  = gf_mul(p30, p30);
    p120 = gf_mul(p60, p60);
    p240 = gf_mul(p120, p120);
    p252 = gf_mul(p240, p12);
    inv  = gf_mul(p252, p2);
    y    = inv ^ rotl8(inv, 1) ^ rotl8(inv, 2) ^ rotl8(inv, 3) ^ rotl8(inv, 4) ^ 8'h63;
  end
endmodule

// File: rtl/aes_lane_round.sv
module aes_lane_round
  import vec_aes_pkg::*;
(
  input  logic [LANE_W-1:0] state,
  input  logic [LANE_W-1:0] rkey,
  output logic [LANE_W-1:0] result
);
  logic [7:0] shifted [LANE_BYTES];
  logic [7:0] subbed  [LANE_BYTES];
  logic [LANE_W-1:0] mixed;

  for (genvar c = 0; c < COLS; c++) begin : g_col
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      // row r rotates left by r columns
      assign shifted[c*ROWS + r] = state[BYTE_W*((((c + r) % COLS) * ROWS) + r) +: BYTE_W];
      aes_sbox_calc u_sbox (
        .a (shifted[c*ROWS + r]),
        .y (subbed[c*ROWS + r])
      );
    end

    logic [7:0] b0, b1, b2, b3;
    assign b0 = subbed[c*ROWS + 0];
    assign b1 = subbed[c*ROWS + 1];
    assign b2 = subbed[c*ROWS + 2];
    assign b3 = subbed[c*ROWS + 3];

    always_comb begin
      mixed[BYTE_W*(c*ROWS+0) +: BYTE_W] = gf_dbl(b0) ^ gf_dbl(b1) ^ b1 ^ b2 ^ b3;
      mixed[BYTE_W*(c*ROWS+1) +: BYTE_W] = b0 ^ gf_dbl(b1) ^ gf_dbl(b2) ^ b2 ^ b3;
      mixed[BYTE_W*(c*ROWS+2) +: BYTE_W] = b0 ^ b1 ^ gf_dbl(b2) ^ gf_dbl(b3) ^ b3;
      mixed[BYTE_W*(c*ROWS+3) +: BYTE_W] = gf_dbl(b0) ^ b0 ^ b1 ^ b2 ^ gf_dbl(b3);
    end
  end

  assign result = mixed ^ rkey;
endmodule

// File: rtl/vec_aes_round.sv
module vec_aes_round
  import vec_aes_pkg::*;
#(
  parameter int N_LANES = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic                        in_legacy,
  input  logic [1:0]                  in_lanes_code,
  input  logic [N_LANES*LANE_W-1:0]   in_dest,
  input  logic [N_LANES*LANE_W-1:0]   in_src1,
  input  logic [N_LANES*LANE_W-1:0]   in_key,
  output logic                        out_valid,
  output logic [N_LANES*LANE_W-1:0]   out_data,
  output logic [N_LANES-1:0]          out_lane_mask
);
  localparam int VEC_W = N_LANES * LANE_W;

  logic [3:0]         lane_cnt;
  logic [N_LANES-1:0] nxt_mask;
  logic [VEC_W-1:0]   nxt_data;
  logic [VEC_W-1:0]   lane_res;

  always_comb begin
    if (in_legacy) lane_cnt = 4'd1;
    else begin
      unique case (in_lanes_code)
        2'd0:    lane_cnt = 4'd1;
        2'd1:    lane_cnt = 4'd2;
        default: lane_cnt = 4'd4;
      endcase
    end
  end

  for (genvar n = 0; n < N_LANES; n++) begin : g_lane
    logic [LANE_W-1:0] st;
    assign st = (in_legacy && n == 0) ? in_dest[n*LANE_W +: LANE_W]
                                      : in_src1[n*LANE_W +: LANE_W];
    aes_lane_round u_round (
      .state  (st),
      .rkey   (in_key[n*LANE_W +: LANE_W]),
      .result (lane_res[n*LANE_W +: LANE_W])
    );
    always_comb begin
      nxt_mask[n] = (n < int'(lane_cnt));
      if (nxt_mask[n])    nxt_data[n*LANE_W +: LANE_W] = lane_res[n*LANE_W +: LANE_W];
      else if (in_legacy) nxt_data[n*LANE_W +: LANE_W] = in_dest[n*LANE_W +: LANE_W];
      else                nxt_data[n*LANE_W +: LANE_W] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_lane_mask <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_lane_mask <= nxt_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) out_data <= nxt_data;
  end

  assert_valid_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_mask_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_lane_mask[0] && $countones({1'b0, out_lane_mask} + 1'b1) == 1));
  assert_zero_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_legacy && in_lanes_code == 2'd0) |=> (out_data[VEC_W-1:LANE_W] == '0));
  assert_keep_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_legacy) |=> (out_data[VEC_W-1:LANE_W] == $past(in_dest[VEC_W-1:LANE_W])
                                 && out_lane_mask == 1));
endmodule

// File: tb/vec_aes_round_test.sv
module vec_aes_round_test;
  localparam int CLK_P = 10;
  localparam int WD_CYCLES = 200000;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid, in_legacy;
  logic [1:0]   in_lanes_code;
  logic [511:0] in_dest, in_src1, in_key;
  logic         out_valid;
  logic [511:0] out_data;
  logic [3:0]   out_lane_mask;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  logic [511:0] exp_q[$];
  logic [3:0]   msk_q[$];
  string        tag_q[$];
  logic [511:0] last_exp;

  always #(CLK_P/2) clk = ~clk;

  vec_aes_round uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_legacy(in_legacy),
    .in_lanes_code(in_lanes_code), .in_dest(in_dest), .in_src1(in_src1),
    .in_key(in_key), .out_valid(out_valid), .out_data(out_data),
    .out_lane_mask(out_lane_mask)
  );

  function automatic logic [127:0] bswap(input logic [127:0] v);
    logic [127:0] o;
    for (int i = 0; i < 16; i++) o[8*i +: 8] = v[8*(15-i) +: 8];
    return o;
  endfunction

  // published round vectors, converted to byte 0 = LSB
  logic [127:0] F, K1, E1, Z, S52, R63, G, Ka, Kb, Kc, K2, U1, U2, U3;
  initial begin
    F   = bswap(128'h00102030405060708090a0b0c0d0e0f0);
    K1  = bswap(128'hd6aa74fdd2af72fadaa678f1d6ab76fe);
    E1  = bswap(128'h89d810e8855ace682d1843d8cb128fe4);
    Z   = '0;
    S52 = {16{8'h52}};
    R63 = {16{8'h63}};
    G   = 128'hdeadbeef_01234567_89abcdef_cafef00d;
    Ka  = 128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0;
    Kb  = 128'h11111111_22222222_33333333_44444444;
    Kc  = 128'ha5a5a5a5_5a5a5a5a_ffff0000_0000ffff;
    K2  = 128'h13579bdf_2468ace0_fedcba98_76543210;
    U1  = 128'h01010101_02020202_03030303_04040404;
    U2  = 128'h99887766_55443322_11009988_77665544;
    U3  = 128'hfedcba98_76543210_0f0f0f0f_f0f0f0f0;
  end

  task automatic finish_run();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic check(input bit ok, input string tag, input logic [511:0] act,
                       input logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic leg, input logic [1:0] code, input logic [511:0] dst,
                       input logic [511:0] s1, input logic [511:0] ky,
                       input logic [511:0] exp, input logic [3:0] msk, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_legacy = leg; in_lanes_code = code;
    in_dest = dst; in_src1 = s1; in_key = ky;
    exp_q.push_back(exp); msk_q.push_back(msk); tag_q.push_back(tag);
    last_exp = exp;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n === 1'b1 && out_valid === 1'b1) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected out_valid", out_data, '0);
      end else begin
        logic [511:0] e;
        logic [3:0] m;
        string t;
        e = exp_q.pop_front(); m = msk_q.pop_front(); t = tag_q.pop_front();
        check(out_data === e, t, out_data, e);
        check(out_lane_mask === m, {t, " mask R5"}, {508'b0, out_lane_mask}, {508'b0, m});
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_CYCLES && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cyc, WD_CYCLES);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_legacy = 1'b0; in_lanes_code = 2'd0;
    in_dest = '0; in_src1 = '0; in_key = '0;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R1 reset valid", {511'b0, out_valid}, '0);
    check(out_lane_mask === 4'b0, "R1 reset mask", {508'b0, out_lane_mask}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0, "R2 idle after reset", {511'b0, out_valid}, '0);

    // R3 R6 R9: one lane, three-operand
    drive(1'b0, 2'd0, {G, U1, U2, U3}, {G, G, G, F}, {Ka, Kb, Kc, K1},
          {Z, Z, Z, E1}, 4'b0001, "R3 R6 one lane");
    // R4 R8 R6: two lanes
    drive(1'b0, 2'd1, {U1, U1, U1, U1}, {G, G, Z, F}, {Ka, Kb, Kc, K1},
          {Z, Z, R63 ^ Kc, E1}, 4'b0011, "R4 R8 R6 two lanes");
    // R4 R8: four lanes, key linearity in lane 1
    drive(1'b0, 2'd2, {G, G, G, G}, {Z, F, F, S52}, {Kc, K1, K2, Kb},
          {R63 ^ Kc, E1, E1 ^ K1 ^ K2, Kb}, 4'b1111, "R4 R8 four lanes");
    // R5: code 3 acts as four lanes
    drive(1'b0, 2'd3, {U3, U2, U1, G}, {F, S52, Z, F}, {K1, Ka, Kb, K1},
          {E1, Ka, R63 ^ Kb, E1}, 4'b1111, "R5 code3 four lanes");
    // R7: legacy, code ignored, src1 ignored
    drive(1'b1, 2'd1, {U3, U2, U1, F}, {G, G, G, S52}, {Ka, Kb, Kc, K1},
          {U3, U2, U1, E1}, 4'b0001, "R7 legacy code1");
    drive(1'b1, 2'd2, {U1, U3, U2, Z}, {F, F, F, F}, {Ka, Ka, Ka, Kb},
          {U1, U3, U2, R63 ^ Kb}, 4'b0001, "R7 R8 legacy code2");
    // R9: different dest gives the same result as the four-lane case
    drive(1'b0, 2'd2, {U1, U2, U3, F}, {Z, F, F, S52}, {Kc, K1, K2, Kb},
          {R63 ^ Kc, E1, E1 ^ K1 ^ K2, Kb}, 4'b1111, "R9 dest ignored");

    @(negedge clk);
    in_valid = 1'b0;
    in_src1 = {F, F, F, F}; in_key = {K1, K1, K1, K1}; in_dest = '0;
    @(negedge clk);
    check(out_valid === 1'b0, "R2 valid low when idle", {511'b0, out_valid}, '0);
    check(out_data === last_exp, "R2 data held", out_data, last_exp);
    @(negedge clk);
    check(out_data === last_exp, "R2 data still held", out_data, last_exp);
    check(exp_q.size() == 0, "R2 all results seen", 512'(exp_q.size()), '0);
    done = 1;
    finish_run();
  end
endmodule